// File: doc/BRIEF.md
# Cursor and light-pen unit

This unit sits beside the raster timing counters of a character display controller. Each cycle it compares the character address being fetched from refresh memory against a programmed cursor address. When the two match, display enable is high and the current scan line of the character cell falls inside a programmed band, it raises the cursor output. The band is given by a first and a last scan line, so the cursor can be a thin underline, a full block or any band in between. A two-bit mode field turns the cursor on steadily or off, or makes it blink at one of two rates. The blink rates are derived from a count of field pulses.

The same unit also captures the light-pen position. The pen strobe is asynchronous to the controller clock, so it passes through a synchronizer chain. On its first rising edge the unit latches the refresh address present at that moment. Each new edge replaces the previous capture, and a strobe that stays high does not capture again.

Top module: `crsr_lpen_unit`

## Requirements
- R1: After reset, `cursor_out` is 0, `pen_addr` is 0 and the field count is 0.
- R2: With mode 00 (steady), `cursor_out` is 1 in the cycle after one in which `disp_en` is 1, `refr_addr` equals `cur_addr`, and `scan_row` lies between `cur_start_cfg[4:0]` and `cur_end_row` inclusive. Both band edges are included.
- R3: When `refr_addr` differs from `cur_addr`, `cursor_out` is 0 in the following cycle.
- R4: When `disp_en` is 0, `cursor_out` is 0 in the following cycle.
- R5: A `scan_row` below the start line or above the end line gives no cursor. A start line greater than the end line gives no cursor for any row.
- R6: Mode 01 (`cur_start_cfg[6:5]`) suppresses the cursor entirely.
- R7: Mode 10 blinks the cursor with a period of 16 fields. The cursor is visible while bit 3 of the field count is 0. The count advances by one on each cycle in which `field_pulse` is 1.
- R8: Mode 11 blinks the cursor with a period of 32 fields. The cursor is visible while bit 4 of the field count is 0.
- R9: Suppose `pen_strobe` is first sampled high at clock edge k. Then at edge k+2 `pen_addr` takes the `refr_addr` value present at that edge. Holding the strobe high captures nothing further.
- R10: Each later rising edge of `pen_strobe` overwrites the previous captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refr_addr | input | 14 | Current refresh memory address |
| scan_row | input | 5 | Current scan line within the character row |
| disp_en | input | 1 | Display enable from the timing counters |
| field_pulse | input | 1 | One-cycle pulse at the start of each field |
| cur_start_cfg | input | 7 | Bits 4:0 first cursor line, bits 6:5 cursor mode |
| cur_end_row | input | 5 | Last cursor scan line |
| cur_addr | input | 14 | Cursor character address |
| pen_strobe | input | 1 | Asynchronous light-pen strobe |
| cursor_out | output | 1 | Cursor video, active high |
| pen_addr | output | 14 | Captured light-pen refresh address |

## Verification
A wrong comparison or band test inside the cursor path shows at `cursor_out` one cycle after the offending input pattern, so each table entry checks one cycle of behaviour. A field counter that advances too fast, too slowly or on the wrong bit only shows up after 8 or 16 field pulses, when visibility should flip. For that reason the blink tests count pulses across whole half-periods. A synchronizer of the wrong depth, or an edge detector that fires on a level, changes the cycle in which `pen_addr` moves or lets a held strobe re-capture. The bench therefore samples one edge early, exactly on time, and again after the address has changed under a held strobe.

// File: rtl/crsr_pkg.sv
package crsr_pkg;
   typedef enum logic [1:0] {
      CM_STEADY     = 2'b00,
      CM_OFF        = 2'b01,
      CM_BLINK_FAST = 2'b10,
      CM_BLINK_SLOW = 2'b11
   } crsr_mode_e;
endpackage

// File: rtl/crsr_blink_gen.sv
module crsr_blink_gen
   import crsr_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       field_pulse,
   input  crsr_mode_e mode,
   output logic       visible
);
   localparam int FAST_BIT = CNT_W - 2;
   localparam int SLOW_BIT = CNT_W - 1;

   initial begin
      if (CNT_W < 2) $error("crsr_blink_gen: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] field_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           field_cnt <= '0;
      else if (field_pulse) field_cnt <= field_cnt + 1'b1;
   end

   always_comb begin
      unique case (mode)
         CM_STEADY:     visible = 1'b1;
         CM_OFF:        visible = 1'b0;
         CM_BLINK_FAST: visible = ~field_cnt[FAST_BIT];
         default:       visible = ~field_cnt[SLOW_BIT];
      endcase
   end

   // R1: the counter leaves reset at zero
   assert_cnt_reset_R1: assert property (@(posedge clk)
      $fell(rst_n) |=> field_cnt == '0);
endmodule

// File: rtl/crsr_hit_detect.sv
module crsr_hit_detect #(
   parameter int ADDR_W = 14,
   parameter int ROW_W  = 5
) (
   input  logic [ADDR_W-1:0] refr_addr,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ROW_W-1:0]  scan_row,
   input  logic [ROW_W-1:0]  first_row,
   input  logic [ROW_W-1:0]  last_row,
   input  logic              disp_en,
   output logic              hit
);
   logic addr_eq, above_first, below_last;

   always_comb begin
      addr_eq     = (refr_addr == cur_addr);
      above_first = (scan_row >= first_row);
      below_last  = (scan_row <= last_row);
      hit         = disp_en & addr_eq & above_first & below_last;
   end
endmodule

// File: rtl/pen_capture.sv
module pen_capture #(
   parameter int ADDR_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W-1:0] refr_addr,
   output logic [ADDR_W-1:0] pen_addr
);
   initial begin
      if (SYNC_STAGES < 2) $error("pen_capture: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    pen_addr <= '0;
      else if (rise) pen_addr <= refr_addr;
   end

   // R9: any change of the capture holds the address of that edge
   assert_pen_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pen_addr) |-> pen_addr == $past(refr_addr));
   // R9: a held strobe never captures twice in a row
   assert_pen_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pen_addr) |=> $stable(pen_addr));
endmodule

// File: rtl/crsr_lpen_unit.sv
module crsr_lpen_unit
   import crsr_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int ROW_W       = 5,
   parameter int FIELD_CNT_W = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b1,
   localparam int CFG_W      = ROW_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] refr_addr,
   input  logic [ROW_W-1:0]  scan_row,
   input  logic              disp_en,
   input  logic              field_pulse,
   input  logic [CFG_W-1:0]  cur_start_cfg,
   input  logic [ROW_W-1:0]  cur_end_row,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              pen_strobe,
   output logic              cursor_out,
   output logic [ADDR_W-1:0] pen_addr
);
   initial begin
      if (ADDR_W < 1) $error("crsr_lpen_unit: ADDR_W must be positive");
      if (ROW_W < 1)  $error("crsr_lpen_unit: ROW_W must be positive");
   end

   crsr_mode_e       mode;
   logic [ROW_W-1:0] first_row;
   logic             hit, visible, cur_next;

   assign mode      = crsr_mode_e'(cur_start_cfg[CFG_W-1:ROW_W]);
   assign first_row = cur_start_cfg[ROW_W-1:0];

   crsr_hit_detect #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_hit (
      .refr_addr (refr_addr),
      .cur_addr  (cur_addr),
      .scan_row  (scan_row),
      .first_row (first_row),
      .last_row  (cur_end_row),
      .disp_en   (disp_en),
      .hit       (hit)
   );

   crsr_blink_gen #(.CNT_W(FIELD_CNT_W)) u_blink (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_pulse (field_pulse),
      .mode        (mode),
      .visible     (visible)
   );

   assign cur_next = hit & visible;

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) cursor_out <= 1'b0;
            else        cursor_out <= cur_next;
         end

         // R4: no cursor without display enable in the previous cycle
         assert_cursor_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cursor_out |-> $past(disp_en));
         // R3: cursor only on the programmed address
         assert_cursor_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cursor_out |-> $past(refr_addr) == $past(cur_addr));
         // R5: cursor only inside the scan-line band
         assert_cursor_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cursor_out |-> ($past(scan_row) >= $past(cur_start_cfg[ROW_W-1:0]))
                        && ($past(scan_row) <= $past(cur_end_row)));
         // R6: off mode never shows the cursor
         assert_cursor_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cursor_out |-> $past(cur_start_cfg[CFG_W-1:ROW_W]) != 2'b01);
      end else begin : g_comb_out
         assign cursor_out = cur_next;
      end
   endgenerate

   pen_capture #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_pen (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (pen_strobe),
      .refr_addr (refr_addr),
      .pen_addr  (pen_addr)
   );
endmodule

// File: tb/sim_crsr_lpen_unit.sv
module sim_crsr_lpen_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [13:0] refr_addr;
   logic [4:0]  scan_row;
   logic        disp_en;
   logic        field_pulse;
   logic [6:0]  cur_start_cfg;
   logic [4:0]  cur_end_row;
   logic [13:0] cur_addr;
   logic        pen_strobe;
   logic        cursor_out;
   logic [13:0] pen_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   crsr_lpen_unit u0 (
      .clk(clk), .rst_n(rst_n), .refr_addr(refr_addr), .scan_row(scan_row),
      .disp_en(disp_en), .field_pulse(field_pulse), .cur_start_cfg(cur_start_cfg),
      .cur_end_row(cur_end_row), .cur_addr(cur_addr), .pen_strobe(pen_strobe),
      .cursor_out(cursor_out), .pen_addr(pen_addr)
   );

   typedef struct packed {
      logic [13:0] addr;
      logic [4:0]  row;
      logic        de;
      logic [13:0] caddr;
      logic [6:0]  scfg;
      logic [4:0]  erow;
      logic        exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{14'h1234, 5'd4,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b1}, // R2 inside band
      '{14'h1234, 5'd3,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b1}, // R2 first line
      '{14'h1234, 5'd6,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b1}, // R2 last line
      '{14'h1234, 5'd2,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b0}, // R5 below band
      '{14'h1234, 5'd7,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b0}, // R5 above band
      '{14'h1235, 5'd4,  1'b1, 14'h1234, 7'h03, 5'd6,  1'b0}, // R3 mismatch
      '{14'h1234, 5'd4,  1'b0, 14'h1234, 7'h03, 5'd6,  1'b0}, // R4 no enable
      '{14'h1234, 5'd4,  1'b1, 14'h1234, 7'h23, 5'd6,  1'b0}, // R6 off mode
      '{14'h1234, 5'd4,  1'b1, 14'h1234, 7'h07, 5'd2,  1'b0}, // R5 start > end
      '{14'h0000, 5'd31, 1'b1, 14'h0000, 7'h00, 5'd31, 1'b1}, // R2 full cell
      '{14'h3FFF, 5'd0,  1'b1, 14'h3FFF, 7'h00, 5'd0,  1'b1}, // R2 single line
      '{14'h0100, 5'd1,  1'b1, 14'h0100, 7'h41, 5'd1,  1'b1}  // R7 fast blink, count 0
   };

   task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         field_pulse = 1'b1;
         @(negedge clk);
         field_pulse = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; refr_addr = '0; scan_row = '0; disp_en = 1'b0; field_pulse = 1'b0;
      cur_start_cfg = '0; cur_end_row = '0; cur_addr = 14'h0001; pen_strobe = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 cursor", {13'd0, cursor_out}, 14'd0);
      check("R1 pen", pen_addr, 14'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         refr_addr = VECS[i].addr; scan_row = VECS[i].row; disp_en = VECS[i].de;
         cur_addr = VECS[i].caddr; cur_start_cfg = VECS[i].scfg; cur_end_row = VECS[i].erow;
         @(negedge clk);
         check($sformatf("R2-table %0d", i), {13'd0, cursor_out}, {13'd0, VECS[i].exp});
      end

      // R7: fast blink hides after 8 fields, returns after 16
      pulses(8);
      @(negedge clk);
      check("R7 hidden at 8", {13'd0, cursor_out}, 14'd0);
      pulses(8);
      @(negedge clk);
      check("R7 visible at 16", {13'd0, cursor_out}, 14'd1);

      // R8: slow blink, count 16 hidden, count 32 (wraps to 0) visible
      cur_start_cfg = 7'h61;
      @(negedge clk);
      @(negedge clk);
      check("R8 hidden at 16", {13'd0, cursor_out}, 14'd0);
      pulses(16);
      @(negedge clk);
      check("R8 visible at 32", {13'd0, cursor_out}, 14'd1);

      // R9: capture timing
      refr_addr = 14'h0ABC;
      pen_strobe = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R9 not before edge k+2", pen_addr, 14'd0);
      @(negedge clk);
      check("R9 capture", pen_addr, 14'h0ABC);
      refr_addr = 14'h0123;
      repeat (4) @(negedge clk);
      check("R9 held strobe no recapture", pen_addr, 14'h0ABC);

      // R10: new edge overwrites
      pen_strobe = 1'b0;
      repeat (4) @(negedge clk);
      refr_addr = 14'h2DEF;
      pen_strobe = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 overwrite", pen_addr, 14'h2DEF);

      // R1: reset clears capture and cursor again
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 pen after reset", pen_addr, 14'd0);
      check("R1 cursor after reset", {13'd0, cursor_out}, 14'd0);
      finish_run();
   end
endmodule